// File: doc/BRIEF.md
# Address-threshold write-protect controller

This block decides, for every decoded command of a serial non-volatile memory, whether that command may run. It holds three pieces of state: the erase/write enable state, an armed flag for privileged protect-register commands, and the protect register. The protect register is an address threshold with a separate "set" flag and a one-shot permanent lock. While the register is set, every location at or above the threshold is shielded from erase and write. While it is cleared, nothing is shielded.

The serial front end shifts a command in. It then pulses `cmd_valid` with the decoded opcode class, the address and the levels of the two enable pins sampled during loading. One clock later the block answers with a single-cycle `res_valid` and an allow/abort flag in `res_allow`. In the same edge it updates its own state if the command was allowed. The current threshold and set flag are always visible for readback. The memory array, serial shifting and program-cycle timing are handled elsewhere.

Top module: `wp_ctrl`

## Requirements
- R1: After reset the block is erase/write disabled, disarmed and unlocked, `prot_set` is 0, `prot_addr` is 0 and `res_valid` is 0.
- R2: A `cmd_valid` pulse sampled at a clock edge produces `res_valid`=1 for exactly the following cycle, with the verdict on `res_allow`. `res_allow` is never 1 without `res_valid`.
- R3: Opcode codes are READ=0, EWEN=1, EWDS=2, ERASE=3, WRITE=4, ERAL=5, WRAL=6, PRREAD=7, PREN=8, PRCLEAR=9, PRWRITE=10, PRDS=11, and codes 12 to 15 are always aborted. ERASE and WRITE abort while disabled. EWEN is allowed only with the PE pin high and enables. EWDS disables.
- R4: While `prot_set`=1, ERASE and WRITE to an address greater than or equal to `prot_addr` abort, and those below it are allowed. While `prot_set`=0, any address is allowed.
- R5: ERAL and WRAL are allowed only when enabled and `prot_set`=0.
- R6: READ, EWEN, EWDS, ERASE, WRITE, ERAL and WRAL abort when the PRE pin is high. READ is allowed with PRE low whatever the enable state. PRREAD is allowed only with PRE high.
- R7: PREN is allowed only when enabled with both PRE and PE high. An allowed PREN arms the block.
- R8: PRCLEAR, PRWRITE and PRDS are allowed only when the immediately preceding command was an allowed PREN, and only with PRE and PE high. Every command, allowed or not, other than an allowed PREN, leaves the block disarmed.
- R9: PRWRITE is allowed only while `prot_set`=0. It loads `cmd_addr` into `prot_addr` and sets `prot_set`. PRCLEAR returns `prot_set` and `prot_addr` to 0.
- R10: After an allowed PRDS, every later PRCLEAR, PRWRITE and PRDS aborts until reset, and the protect register never changes again.
- R11: An aborted command changes neither `prot_addr`, `prot_set` nor the enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is complete |
| cmd_op | input | 4 | Opcode class (codes in R3) |
| cmd_addr | input | ADDR_W | Command address; new threshold for PRWRITE |
| pin_pe | input | 1 | Program-enable pin level sampled while loading |
| pin_pre | input | 1 | Protect-register-enable pin level sampled while loading |
| res_valid | output | 1 | Verdict strobe, one cycle after `cmd_valid` |
| res_allow | output | 1 | 1 = run the command, 0 = abort |
| prot_addr | output | ADDR_W | Protect threshold readback |
| prot_set | output | 1 | 1 = threshold active, 0 = register cleared |

## Verification
Each verdict comes from one register stage. A command strobed at a rising edge has its `res_valid`/`res_allow` visible right after that edge, and the state it changes (threshold, set flag, enable, lock) moves in the same edge. The bench drives each strobe on a falling edge, waits for one rising edge, and samples the verdict and the readback at the next falling edge. It then confirms one cycle later that the strobe has ended. Enable state, arming and lock have no port, so their effect is observed through the verdicts of the commands that follow.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_READ    = 4'd0,
    OP_EWEN    = 4'd1,
    OP_EWDS    = 4'd2,
    OP_ERASE   = 4'd3,
    OP_WRITE   = 4'd4,
    OP_ERAL    = 4'd5,
    OP_WRAL    = 4'd6,
    OP_PRREAD  = 4'd7,
    OP_PREN    = 4'd8,
    OP_PRCLEAR = 4'd9,
    OP_PRWRITE = 4'd10,
    OP_PRDS    = 4'd11
  } wp_op_e;

  typedef struct packed {
    logic ewen;
    logic armed;
    logic locked;
    logic pset;
  } wp_flags_t;
endpackage

// File: rtl/wp_decide.sv
module wp_decide
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pe,
  input  logic              pre,
  input  wp_flags_t         flags,
  input  logic [ADDR_W-1:0] thr,
  output logic              allow
);
  logic in_region;
  logic priv_ok;

  assign in_region = flags.pset && (addr >= thr);
  assign priv_ok   = flags.armed && pre && pe && !flags.locked;

  always_comb begin
    allow = 1'b0;
    case (op)
      OP_READ:    allow = !pre;
      OP_EWEN:    allow = !pre && pe;
      OP_EWDS:    allow = !pre;
      OP_ERASE,
      OP_WRITE:   allow = !pre && flags.ewen && !in_region;
      OP_ERAL,
      OP_WRAL:    allow = !pre && flags.ewen && !flags.pset;
      OP_PRREAD:  allow = pre;
      OP_PREN:    allow = flags.ewen && pre && pe;
      OP_PRCLEAR,
      OP_PRDS:    allow = priv_ok;
      OP_PRWRITE: allow = priv_ok && !flags.pset;
      default:    allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/wp_state.sv
module wp_state
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              allow,
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] addr,
  output wp_flags_t         flags,
  output logic [ADDR_W-1:0] thr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      thr   <= '0;
    end else if (upd) begin
      flags.armed <= allow && (op == OP_PREN);
      if (allow) begin
        case (op)
          OP_EWEN:    flags.ewen <= 1'b1;
          OP_EWDS:    flags.ewen <= 1'b0;
          OP_PRCLEAR: begin
            flags.pset <= 1'b0;
            thr        <= '0;
          end
          OP_PRWRITE: begin
            flags.pset <= 1'b1;
            thr        <= addr;
          end
          OP_PRDS:    flags.locked <= 1'b1;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pin_pe,
  input  logic              pin_pre,
  output logic              res_valid,
  output logic              res_allow,
  output logic [ADDR_W-1:0] prot_addr,
  output logic              prot_set
);
  wp_flags_t         flags;
  logic [ADDR_W-1:0] thr;
  logic              allow_c;
  logic              ewen_q;
  logic              lock_q;

  wp_decide #(.ADDR_W(ADDR_W)) u_decide (
    .op(cmd_op), .addr(cmd_addr), .pe(pin_pe), .pre(pin_pre),
    .flags(flags), .thr(thr), .allow(allow_c)
  );

  wp_state #(.ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst(rst), .upd(cmd_valid), .allow(allow_c),
    .op(cmd_op), .addr(cmd_addr), .flags(flags), .thr(thr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
    end else begin
      res_valid <= cmd_valid;
      res_allow <= cmd_valid && allow_c;
    end
  end

  assign prot_addr = thr;
  assign prot_set  = flags.pset;
  assign ewen_q    = flags.ewen;
  assign lock_q    = flags.locked;
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              res_valid,
  input logic              res_allow,
  input logic [ADDR_W-1:0] prot_addr,
  input logic              prot_set,
  input logic              ewen,
  input logic              locked
);
  logic is_pgm;
  logic is_all;
  assign is_pgm = (cmd_op == OP_ERASE) || (cmd_op == OP_WRITE);
  assign is_all = (cmd_op == OP_ERAL) || (cmd_op == OP_WRAL);

  assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> res_valid);
  assert_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !res_valid);
  assert_allow_in_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    res_allow |-> res_valid);
  assert_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_pgm && !ewen) |=> !res_allow);
  assert_threshold_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_pgm && prot_set && (cmd_addr >= prot_addr)) |=> !res_allow);
  assert_bulk_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_all && prot_set) |=> !res_allow);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(prot_addr) && $stable(prot_set) && locked));
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(prot_addr) && $stable(prot_set) && $stable(ewen)));
endmodule

bind wp_ctrl wp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .res_valid(res_valid), .res_allow(res_allow),
  .prot_addr(prot_addr), .prot_set(prot_set), .ewen(ewen_q), .locked(lock_q)
);

// File: tb/wp_ctrl_tb.sv
module wp_ctrl_tb;
  import wp_pkg::*;
  localparam int unsigned ADDR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic pin_pe = 1'b0;
  logic pin_pre = 1'b0;
  logic res_valid, res_allow, prot_set;
  logic [ADDR_W-1:0] prot_addr;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wp_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .pin_pe(pin_pe), .pin_pre(pin_pre),
    .res_valid(res_valid), .res_allow(res_allow),
    .prot_addr(prot_addr), .prot_set(prot_set)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [ADDR_W-1:0] a,
                       input logic pe, input logic pre, input logic exp,
                       input string tag);
    cmd_op = op; cmd_addr = a; pin_pe = pe; pin_pre = pre; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " res_valid"}, int'(res_valid), 1);
    chk({tag, " res_allow"}, int'(res_allow), int'(exp));
  endtask

  task automatic chk_prot(input logic [ADDR_W-1:0] a, input logic s, input string tag);
    chk({tag, " prot_addr"}, int'(prot_addr), int'(a));
    chk({tag, " prot_set"}, int'(prot_set), int'(s));
  endtask

  task automatic t_reset;
    chk("R1 res_valid", int'(res_valid), 0);
    chk_prot('0, 1'b0, "R1");
    issue(OP_WRITE, 8'h05, 1, 0, 0, "R1 write while disabled after reset");
  endtask

  task automatic t_enable;
    issue(OP_ERASE, 8'h05, 1, 0, 0, "R3 erase disabled");
    issue(OP_READ,  8'h05, 0, 0, 1, "R6 read while disabled");
    issue(OP_EWEN,  8'h00, 0, 0, 0, "R3 ewen pe low");
    issue(OP_WRITE, 8'h05, 1, 0, 0, "R11 still disabled");
    issue(OP_EWEN,  8'h00, 1, 1, 0, "R6 ewen pre high");
    issue(OP_EWEN,  8'h00, 1, 0, 1, "R3 ewen");
    issue(OP_WRITE, 8'hFF, 0, 0, 1, "R4 cleared protects nothing");
    issue(OP_WRITE, 8'h05, 1, 1, 0, "R6 write pre high");
    issue(OP_EWDS,  8'h00, 0, 0, 1, "R3 ewds");
    issue(OP_WRITE, 8'h05, 1, 0, 0, "R3 write after ewds");
    issue(OP_READ,  8'h05, 0, 0, 1, "R6 read after ewds");
    issue(OP_PREN,  8'h00, 1, 1, 0, "R7 pren while disabled");
    issue(OP_EWEN,  8'h00, 1, 0, 1, "R3 re-enable");
    issue(4'd13,    8'h00, 1, 0, 0, "R3 reserved code");
  endtask

  task automatic t_pulse;
    issue(OP_READ, 8'h01, 0, 0, 1, "R2 read");
    @(posedge clk);
    @(negedge clk);
    chk("R2 strobe ends", int'(res_valid), 0);
    chk("R2 allow ends", int'(res_allow), 0);
  endtask

  task automatic t_arm;
    issue(OP_PREN,    8'h00, 0, 1, 0, "R7 pren pe low");
    issue(OP_PRWRITE, 8'h40, 1, 1, 0, "R8 prwrite unarmed");
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren");
    issue(OP_PRREAD,  8'h00, 0, 1, 1, "R6 prread");
    issue(OP_PRWRITE, 8'h40, 1, 1, 0, "R8 disarmed by prread");
    chk_prot('0, 1'b0, "R11 after aborted prwrite");
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren again");
    issue(OP_PRWRITE, 8'h40, 0, 1, 0, "R8 prwrite pe low");
    issue(OP_PRWRITE, 8'h40, 1, 1, 0, "R8 disarmed by abort");
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren third");
    issue(OP_PRWRITE, 8'h40, 1, 1, 1, "R9 prwrite");
    chk_prot(8'h40, 1'b1, "R9 loaded");
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren fourth");
    issue(OP_PRWRITE, 8'h20, 1, 1, 0, "R9 prwrite not cleared");
    chk_prot(8'h40, 1'b1, "R11 unchanged");
  endtask

  task automatic t_threshold;
    issue(OP_WRITE,  8'h3F, 0, 0, 1, "R4 below threshold");
    issue(OP_WRITE,  8'h40, 1, 0, 0, "R4 at threshold");
    issue(OP_ERASE,  8'hFF, 1, 0, 0, "R4 above threshold");
    issue(OP_ERASE,  8'h00, 1, 0, 1, "R4 erase low address");
    issue(OP_ERAL,   8'h00, 1, 0, 0, "R5 eral while set");
    issue(OP_WRAL,   8'h00, 1, 0, 0, "R5 wral while set");
    issue(OP_PRREAD, 8'h00, 0, 0, 0, "R6 prread pre low");
    chk_prot(8'h40, 1'b1, "R11 after aborts");
  endtask

  task automatic t_clear;
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren for clear");
    issue(OP_PRCLEAR, 8'h00, 1, 1, 1, "R9 prclear");
    chk_prot('0, 1'b0, "R9 cleared");
    issue(OP_WRAL,    8'h00, 1, 0, 1, "R5 wral when cleared");
    issue(OP_ERAL,    8'h00, 1, 1, 0, "R6 eral pre high");
    issue(OP_WRITE,   8'hFF, 1, 0, 1, "R4 top address when cleared");
  endtask

  task automatic t_lock;
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren");
    issue(OP_PRWRITE, 8'h80, 1, 1, 1, "R9 prwrite 80");
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren before lock");
    issue(OP_PRDS,    8'h00, 1, 1, 1, "R10 prds");
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren after lock");
    issue(OP_PRCLEAR, 8'h00, 1, 1, 0, "R10 prclear locked");
    chk_prot(8'h80, 1'b1, "R10 kept after prclear");
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren after lock 2");
    issue(OP_PRWRITE, 8'h10, 1, 1, 0, "R10 prwrite locked");
    issue(OP_PREN,    8'h00, 1, 1, 1, "R7 pren after lock 3");
    issue(OP_PRDS,    8'h00, 1, 1, 0, "R10 prds again");
    chk_prot(8'h80, 1'b1, "R10 kept");
    issue(OP_WRITE,   8'h7F, 1, 0, 1, "R4 below locked threshold");
    issue(OP_WRITE,   8'h80, 1, 0, 0, "R4 at locked threshold");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pulse();
    t_arm();
    t_threshold();
    t_clear();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule